// File: doc/BRIEF.md
# Memory Type Range Lookup Unit

This block answers one question for a physical address range: which memory caching type applies to it. A request carries a start address and an exclusive end address. The block answers from whichever source applies first: a 88-entry fixed table for the lowest megabyte, or a set of variable base/mask range entries whose overlaps are merged by a precedence rule. When neither applies, it falls back to a programmed default type. An optional second top-of-memory boundary forces write-back above 4 GiB.

Settings are loaded through one write port. The lookup runs as a small state machine that visits one variable entry per clock. It stops early when the range is only partly covered or when overlapping entries force uncacheable. The block takes one request at a time. The answer is an 8-bit type code with a one-cycle valid strobe. Two reserved codes report special cases: 0xFF when lookups are switched off, and 0xFE when the range is only partly covered.

Top module: `memattr_lookup`

## Requirements
- R1: The answer is 0xFF if no control word has been written since reset, or if the 2-bit enable field of the control word is 00. The control word is write kind 3, with bits 7:0 the default type, bits 9:8 the enable field (bit 9 enables variable ranges) and bit 10 marking that the fixed table exists.
- R2: The fixed table is write kind 0, with the address selecting the byte. When the table exists and start < 0x100000, the answer is the table byte picked by start alone. The index is start>>16 below 0x80000, 8+((start-0x80000)>>14) below 0xC0000, and 24+((start-0xC0000)>>12) otherwise.
- R3: Otherwise, when the variable enable is clear, the answer is the default type.
- R4: Variable entry i uses write kind 1 for its base word and write kind 2 for its mask word. An entry takes part only when mask bit 11 is set. It covers an address when (addr^base)&mask is zero, with bits 11:0 left out of the compare. Its type is base bits 7:0.
- R5: The end address is turned into an inclusive one (end-1) before any compare. If start and the inclusive end disagree on being covered by any one taking-part entry, the answer is 0xFE.
- R6: Covering entries are merged in index order. The first sets the type. Any later entry of type 0 (uncacheable), or any later entry while the merged type is 0, gives 0. Write-back (6) with write-through (4) gives 4. Any other difference gives 0.
- R7: Write kind 4 sets the boundary. After a full scan, if the boundary is nonzero, start >= 2^32 and the inclusive end < the boundary, the answer is 6.
- R8: After a full scan with no covering entry, the answer is the default type.
- R9: reqReady is high only when idle, and a request is taken when reqValid and reqReady are both high. rspValid pulses for one cycle with reqReady already high. Answers from R1 to R3 come 1 cycle after the accepting edge. An exit while visiting entry k comes k+2 cycles after it, and a full scan takes NUM_VAR+1 cycles. Requests made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Setting write strobe |
| wrKind | input | 3 | Write target: 0 fixed byte, 1 base, 2 mask, 3 control, 4 boundary |
| wrAddr | input | 7 | Fixed-table byte index or variable entry index |
| wrData | input | ADDR_W | Write data |
| reqValid | input | 1 | Lookup request |
| reqStart | input | ADDR_W | Range start address |
| reqEnd | input | ADDR_W | Range end address, exclusive |
| reqReady | output | 1 | Idle and able to take a request |
| rspValid | output | 1 | One-cycle answer strobe |
| rspType | output | 8 | Resolved type code |

## Verification
The checker assumes that settings are written only while the block is idle. Its record of the first control write, and the answer it expects for the unloaded case, depend on this. The bench changes settings only between lookups, after the previous answer has arrived. The latency-bound property assumes that each request is accepted only when reqReady is high. The bench drives extra requests while the block is busy, but only in scan cases, and it drops them before the block returns to idle.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  localparam logic [7:0] TYPE_UC   = 8'h00;
  localparam logic [7:0] TYPE_WT   = 8'h04;
  localparam logic [7:0] TYPE_WB   = 8'h06;
  localparam logic [7:0] TYPE_PART = 8'hFE;
  localparam logic [7:0] TYPE_OFF  = 8'hFF;

  localparam logic [2:0] WK_FIX  = 3'd0;
  localparam logic [2:0] WK_BASE = 3'd1;
  localparam logic [2:0] WK_MASK = 3'd2;
  localparam logic [2:0] WK_CTL  = 3'd3;
  localparam logic [2:0] WK_TOM2 = 3'd4;

  localparam int VALID_BIT = 11;
  localparam int PAGE_BITS = 12;
  localparam int FIX_N     = 88;
  localparam int FIX_W     = $clog2(FIX_N);

  typedef enum logic [2:0] {
    RS_OFF, RS_FIXED, RS_DEF, RS_PART, RS_UC, RS_FINAL
  } resSel_e;

  typedef struct packed {
    logic    capture;
    logic    step;
    logic    respond;
    resSel_e sel;
  } mtrStrobe_t;

  typedef struct packed {
    logic loaded;
    logic anyEn;
    logic varEn;
    logic fixedHit;
    logic partial;
    logic ucExit;
    logic lastIdx;
  } mtrStatus_t;

endpackage

// File: rtl/mtr_datapath.sv
module mtr_datapath
  import mtr_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_VAR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrKind,
  input  logic [FIX_W-1:0]  wrAddr,
  input  logic [ADDR_W-1:0] wrData,
  input  logic [ADDR_W-1:0] reqStart,
  input  logic [ADDR_W-1:0] reqEnd,
  input  mtrStrobe_t        strobe,
  output mtrStatus_t        status,
  output logic              rspValid,
  output logic [7:0]        rspType
);

  localparam int IDX_W = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
  localparam int PG_W  = ADDR_W - PAGE_BITS;

  logic [7:0]      fixTab [FIX_N];
  logic [PG_W-1:0] basePg [NUM_VAR];
  logic [7:0]      baseType [NUM_VAR];
  logic [PG_W-1:0] maskPg [NUM_VAR];
  logic            maskOn [NUM_VAR];
  logic [7:0]      defType;
  logic [1:0]      enBits;
  logic            hasFixed;
  logic            loaded;
  logic [ADDR_W-1:0] tom2;

  logic [PG_W-1:0]   startPg;
  logic [ADDR_W-1:0] endQ;
  logic [IDX_W-1:0]  idxQ;
  logic [7:0]        accType;
  logic              accHit;

  // settings write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FIX_N; i++) fixTab[i] <= '0;
      for (int i = 0; i < NUM_VAR; i++) begin
        basePg[i]   <= '0;
        baseType[i] <= '0;
        maskPg[i]   <= '0;
        maskOn[i]   <= 1'b0;
      end
      defType  <= '0;
      enBits   <= '0;
      hasFixed <= 1'b0;
      loaded   <= 1'b0;
      tom2     <= '0;
    end else if (wrEn) begin
      case (wrKind)
        WK_FIX:  if (wrAddr < FIX_W'(FIX_N)) fixTab[wrAddr] <= wrData[7:0];
        WK_BASE: if (wrAddr < FIX_W'(NUM_VAR)) begin
          basePg[wrAddr[IDX_W-1:0]]   <= wrData[ADDR_W-1:PAGE_BITS];
          baseType[wrAddr[IDX_W-1:0]] <= wrData[7:0];
        end
        WK_MASK: if (wrAddr < FIX_W'(NUM_VAR)) begin
          maskPg[wrAddr[IDX_W-1:0]] <= wrData[ADDR_W-1:PAGE_BITS];
          maskOn[wrAddr[IDX_W-1:0]] <= wrData[VALID_BIT];
        end
        WK_CTL: begin
          defType  <= wrData[7:0];
          enBits   <= wrData[9:8];
          hasFixed <= wrData[10];
          loaded   <= 1'b1;
        end
        WK_TOM2: tom2 <= wrData;
        default: ;
      endcase
    end
  end

  // entry under inspection
  logic [PG_W-1:0] selMask;
  logic            entryOn, startIn, endIn, entryHit;
  logic [7:0]      curType, accNext;
  logic            hitNext, ucExit;

  always_comb begin
    selMask  = maskPg[idxQ];
    entryOn  = maskOn[idxQ];
    curType  = baseType[idxQ];
    startIn  = ((startPg ^ basePg[idxQ]) & selMask) == '0;
    endIn    = ((endQ[ADDR_W-1:PAGE_BITS] ^ basePg[idxQ]) & selMask) == '0;
    entryHit = entryOn && startIn;
  end

  always_comb begin
    accNext = accType;
    hitNext = accHit;
    ucExit  = 1'b0;
    if (entryHit) begin
      if (!accHit) begin
        accNext = curType;
        hitNext = 1'b1;
      end else if (accType == TYPE_UC || curType == TYPE_UC) begin
        ucExit = 1'b1;
      end else if ((accType == TYPE_WB && curType == TYPE_WT) ||
                   (accType == TYPE_WT && curType == TYPE_WB)) begin
        accNext = TYPE_WT;
      end else if (accType != curType) begin
        ucExit = 1'b1;
      end
    end
  end

  // fixed table index from the start page number
  logic [FIX_W-1:0] fixIdx;
  always_comb begin
    if (!startPg[7])      fixIdx = FIX_W'(startPg[6:4]);
    else if (!startPg[6]) fixIdx = FIX_W'(8) + FIX_W'(startPg[5:2]);
    else                  fixIdx = FIX_W'(24) + FIX_W'(startPg[5:0]);
  end

  logic       tom2Win;
  logic [7:0] finalType, resType;
  always_comb begin
    tom2Win   = (tom2 != '0) && (startPg[PG_W-1:32-PAGE_BITS] != '0) && (endQ < tom2);
    finalType = tom2Win ? TYPE_WB : (hitNext ? accNext : defType);
    case (strobe.sel)
      RS_OFF:   resType = TYPE_OFF;
      RS_FIXED: resType = fixTab[fixIdx];
      RS_DEF:   resType = defType;
      RS_PART:  resType = TYPE_PART;
      RS_UC:    resType = TYPE_UC;
      default:  resType = finalType;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPg  <= '0;
      endQ     <= '0;
      idxQ     <= '0;
      accType  <= '0;
      accHit   <= 1'b0;
      rspValid <= 1'b0;
      rspType  <= '0;
    end else begin
      if (strobe.capture) begin
        startPg <= reqStart[ADDR_W-1:PAGE_BITS];
        endQ    <= reqEnd - ADDR_W'(1);
        idxQ    <= '0;
        accType <= '0;
        accHit  <= 1'b0;
      end else if (strobe.step) begin
        idxQ    <= idxQ + IDX_W'(1);
        accType <= accNext;
        accHit  <= hitNext;
      end
      rspValid <= strobe.respond;
      if (strobe.respond) rspType <= resType;
    end
  end

  always_comb begin
    status.loaded   = loaded;
    status.anyEn    = |enBits;
    status.varEn    = enBits[1];
    status.fixedHit = hasFixed && (startPg[PG_W-1:8] == '0);
    status.partial  = entryOn && (startIn != endIn);
    status.ucExit   = ucExit;
    status.lastIdx  = (idxQ == IDX_W'(NUM_VAR - 1));
  end

endmodule

// File: rtl/mtr_ctrl.sv
module mtr_ctrl
  import mtr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  mtrStatus_t status,
  output mtrStrobe_t strobe,
  output logic       reqReady
);

  typedef enum logic [1:0] {ST_IDLE, ST_DECIDE, ST_SCAN} ctlState_e;
  ctlState_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        stateNext      = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (!status.loaded || !status.anyEn) begin
          strobe.respond = 1'b1; strobe.sel = RS_OFF;
        end else if (status.fixedHit) begin
          strobe.respond = 1'b1; strobe.sel = RS_FIXED;
        end else if (!status.varEn) begin
          strobe.respond = 1'b1; strobe.sel = RS_DEF;
        end
        stateNext = strobe.respond ? ST_IDLE : ST_SCAN;
      end
      ST_SCAN: begin
        if (status.partial) begin
          strobe.respond = 1'b1; strobe.sel = RS_PART;
        end else if (status.ucExit) begin
          strobe.respond = 1'b1; strobe.sel = RS_UC;
        end else if (status.lastIdx) begin
          strobe.respond = 1'b1; strobe.sel = RS_FINAL;
        end else begin
          strobe.step = 1'b1;
        end
        if (strobe.respond) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/memattr_lookup.sv
module memattr_lookup
  import mtr_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int NUM_VAR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrKind,
  input  logic [FIX_W-1:0]  wrAddr,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqStart,
  input  logic [ADDR_W-1:0] reqEnd,
  output logic              reqReady,
  output logic              rspValid,
  output logic [7:0]        rspType
);

  mtrStrobe_t strobe;
  mtrStatus_t status;

  mtr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .status(status), .strobe(strobe), .reqReady(reqReady)
  );

  mtr_datapath #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind), .wrAddr(wrAddr),
    .wrData(wrData), .reqStart(reqStart), .reqEnd(reqEnd), .strobe(strobe),
    .status(status), .rspValid(rspValid), .rspType(rspType)
  );

endmodule

// File: rtl/memattr_lookup_chk.sv
module memattr_lookup_chk #(
  parameter int NUM_VAR = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] wrKind,
  input logic       reqValid,
  input logic       reqReady,
  input logic       rspValid,
  input logic [7:0] rspType
);

  localparam int CNT_W = $clog2(NUM_VAR + 3) + 1;

  logic             loadedSeen;
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadedSeen <= 1'b0;
      waitCnt    <= '0;
    end else begin
      if (wrEn && wrKind == 3'd3) loadedSeen <= 1'b1;
      if (reqValid && reqReady) waitCnt <= '0;
      else if (!reqReady)       waitCnt <= waitCnt + CNT_W'(1);
    end
  end

  a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  a_r9_ready_with_resp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady);

  a_r9_busy_before_resp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!reqReady));

  a_r9_latency_bound: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (waitCnt >= CNT_W'(1)) && (waitCnt <= CNT_W'(NUM_VAR + 1)));

  a_r1_unloaded_off: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !loadedSeen) |-> (rspType == 8'hFF));

endmodule

bind memattr_lookup memattr_lookup_chk #(.NUM_VAR(NUM_VAR)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind), .reqValid(reqValid),
  .reqReady(reqReady), .rspValid(rspValid), .rspType(rspType)
);

// File: tb/sim_memattr_lookup.sv
module sim_memattr_lookup;

  localparam int AW = 48;
  localparam int NV = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrKind = '0;
  logic [6:0]    wrAddr = '0;
  logic [AW-1:0] wrData = '0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqStart = '0;
  logic [AW-1:0] reqEnd = '0;
  logic          reqReady, rspValid;
  logic [7:0]    rspType;

  int tests = 0;
  int fails = 0;

  // shadow settings
  logic [7:0]    mFix [88];
  logic [AW-1:0] mBase [NV];
  logic [AW-1:0] mMask [NV];
  logic [7:0]    mDef = '0;
  logic [1:0]    mEn = '0;
  logic          mHasFix = 1'b0;
  logic          mLoaded = 1'b0;
  logic [AW-1:0] mTom2 = '0;

  memattr_lookup #(.ADDR_W(AW), .NUM_VAR(NV)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind), .wrAddr(wrAddr),
    .wrData(wrData), .reqValid(reqValid), .reqStart(reqStart), .reqEnd(reqEnd),
    .reqReady(reqReady), .rspValid(rspValid), .rspType(rspType)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    tests++; fails++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [AW-1:0] sizeMask(input int log2Size, input bit on);
    logic [AW-1:0] m;
    m = ({AW{1'b1}} << log2Size) & ~AW'(48'hFFF);
    if (on) m[11] = 1'b1;
    return m;
  endfunction

  task automatic wr(input logic [2:0] kind, input int addr, input logic [AW-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrKind = kind; wrAddr = 7'(addr); wrData = data;
    case (kind)
      3'd0: mFix[addr] = data[7:0];
      3'd1: mBase[addr] = data;
      3'd2: mMask[addr] = data;
      3'd3: begin mDef = data[7:0]; mEn = data[9:8]; mHasFix = data[10]; mLoaded = 1'b1; end
      default: mTom2 = data;
    endcase
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic model(input logic [AW-1:0] s, input logic [AW-1:0] e,
                       output logic [7:0] t, output int lat);
    logic [AW-1:0] ei, m;
    logic [7:0] acc, cur;
    bit hit, sm, em;
    int idx;
    ei = e - 1;
    lat = 1;
    if (!mLoaded || mEn == 2'b00) begin t = 8'hFF; return; end
    if (mHasFix && s < 48'h100000) begin
      if (s < 48'h80000)      idx = int'(s >> 16);
      else if (s < 48'hC0000) idx = 8 + int'((s - 48'h80000) >> 14);
      else                    idx = 24 + int'((s - 48'hC0000) >> 12);
      t = mFix[idx]; return;
    end
    if (!mEn[1]) begin t = mDef; return; end
    hit = 0; acc = 0;
    for (int i = 0; i < NV; i++) begin
      lat = i + 2;
      if (!mMask[i][11]) continue;
      m  = mMask[i] & ~AW'(48'hFFF);
      sm = ((s ^ mBase[i]) & m) == 0;
      em = ((ei ^ mBase[i]) & m) == 0;
      if (sm != em) begin t = 8'hFE; return; end
      if (!sm) continue;
      cur = mBase[i][7:0];
      if (!hit) begin acc = cur; hit = 1; continue; end
      if (acc == 0 || cur == 0) begin t = 8'h00; return; end
      if ((acc == 6 && cur == 4) || (acc == 4 && cur == 6)) acc = 4;
      else if (acc != cur) begin t = 8'h00; return; end
    end
    lat = NV + 1;
    if (mTom2 != 0 && s >= 48'h1_0000_0000 && ei < mTom2) t = 8'h06;
    else if (hit) t = acc;
    else t = mDef;
  endtask

  task automatic lookup(input logic [AW-1:0] s, input logic [AW-1:0] e,
                        input string tag, input bit intrude);
    logic [7:0] expT, gotT;
    int expL, cnt;
    bit got, extra;
    model(s, e, expT, expL);
    @(negedge clk);
    reqValid = 1'b1; reqStart = s; reqEnd = e;
    @(posedge clk);
    @(negedge clk);
    if (intrude) begin reqStart = 48'h0; reqEnd = 48'h1000; end
    else reqValid = 1'b0;
    cnt = 0; got = 0; gotT = 'x;
    while (!got && cnt < 40) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      reqValid = 1'b0;
      if (rspValid) begin got = 1; gotT = rspType; end
    end
    check({tag, " type"}, 64'(gotT), 64'(expT));
    check({tag, " latency R9"}, 64'(cnt), 64'(expL));
    if (intrude) begin
      extra = 0;
      repeat (3) begin @(negedge clk); if (rspValid) extra = 1; end
      check({tag, " R9 busy request ignored"}, 64'(extra), 64'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 88; i++) mFix[i] = '0;
    for (int i = 0; i < NV; i++) begin mBase[i] = '0; mMask[i] = '0; end
    repeat (3) @(negedge clk);
    check("reset rspValid R9", 64'(rspValid), 64'd0);
    check("reset reqReady R9", 64'(reqReady), 64'd1);
    rstN = 1'b1;
    @(negedge clk);

    lookup(48'h1000, 48'h2000, "R1 unloaded", 0);
    for (int i = 0; i < 88; i++) wr(3'd0, i, AW'((i * 37 + 11) & 8'hFF));
    wr(3'd3, 0, AW'(32'h0000_0405));          // enable 00, fixed present
    lookup(48'h1000, 48'h2000, "R1 enable clear", 0);

    wr(3'd3, 0, AW'(32'h0000_0505));          // fixed-only enable
    for (int k = 0; k < 256; k++)
      lookup(AW'(k * 32'h1000), AW'(k * 32'h1000 + 32'h4000_0000), "R2 fixed sweep", 0);
    lookup(48'h100000, 48'h101000, "R3 above fixed", 0);
    wr(3'd3, 0, AW'(32'h0000_0105));          // no fixed table
    lookup(48'h0, 48'h1000, "R3 no fixed", 0);

    wr(3'd3, 0, AW'(32'h0000_0205));          // variable enable, default 5
    wr(3'd1, 0, 48'h1_0000_0006); wr(3'd2, 0, sizeMask(30, 1));
    wr(3'd1, 1, 48'h1_1000_0004); wr(3'd2, 1, sizeMask(28, 1));
    wr(3'd1, 2, 48'h0_2000_0000); wr(3'd2, 2, sizeMask(28, 1));
    wr(3'd1, 3, 48'h0_3000_0001); wr(3'd2, 3, sizeMask(28, 0));
    for (int k = 0; k < 64; k++)
      lookup(AW'(64'(k) * 64'h0800_0000), AW'(64'(k) * 64'h0800_0000 + 64'h1000), "R8 range sweep", 0);
    lookup(48'h0_3000_0000, 48'h0_3000_1000, "R4 entry off", 0);
    lookup(48'h1_0000_0ABC, 48'h1_0000_1000, "R4 page granularity", 0);
    lookup(48'h1_1000_0000, 48'h1_1000_1000, "R6 WB with WT", 1);
    lookup(48'h1_3FFF_F000, 48'h1_4000_1000, "R5 partial", 1);
    lookup(48'h1_3FFF_F000, 48'h1_4000_0000, "R5 exclusive end", 0);
    lookup(48'h0_2000_0000, 48'h0_2000_1000, "R6 single UC", 0);
    lookup(48'h0_9000_0000, 48'h0_9000_1000, "R8 no match", 0);

    wr(3'd1, 1, 48'h0_2000_0005);
    lookup(48'h0_2000_0000, 48'h0_2000_1000, "R6 UC early exit", 1);
    wr(3'd1, 3, 48'h1_0000_0001); wr(3'd2, 3, sizeMask(30, 1));
    lookup(48'h1_0000_0000, 48'h1_0000_1000, "R6 type conflict", 0);

    wr(3'd4, 0, 48'h2_0000_0000);
    lookup(48'h1_8000_0000, 48'h1_8000_1000, "R7 below boundary", 0);
    lookup(48'h1_F000_0000, 48'h2_0000_1000, "R7 end past boundary", 0);
    lookup(48'h0_8000_0000, 48'h0_8000_1000, "R7 start below 4G", 0);
    lookup(48'h1_0000_0000, 48'h1_0000_1000, "R7 UC wins", 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule